// File: doc/BRIEF.md
# Receive Status FIFO

This block buffers received characters together with the error and framing flags that the receiver attached to each one. Every character travels through the queue beside its own flag set, so the flags stay paired with the character they describe. A CPU takes characters from the head of the queue one at a time.

A read-only current-status byte always describes the character at the head. Bit 0 says whether any character is waiting. Bit 1 is always 0. Bits 7 to 2 carry that character's flags, filtered by the active line mode. The status byte is produced combinationally from the head entry. It is therefore valid in the same cycle as the head data. Popping the data moves both the data and the status on to the next entry.

Three synchronous events each empty the queue: a receive-reset command, a channel-reset command and system stop. No output of the block raises an interrupt.

Top module: `rxq_status_fifo`

## Requirements
- R1: After `rst_n` is low at a clock edge, `cur_status` reads 8'h00 and `rd_data` reads 8'h00 until a character is pushed.
- R2: In the cycle after an accepted push into an empty queue, `cur_status[0]` is 1 and `rd_data` shows the pushed character.
- R3: Characters and their flags leave the queue in arrival order. A `rd_pop` while the queue is not empty replaces the head data and head status with those of the next entry.
- R4: When the last entry is popped, `cur_status` returns to 8'h00.
- R5: `cur_status[1]` is always 0. `wr_flags[i]` maps to `cur_status[i+2]`. `mode` selects which status bits may be 1:
  - 2'b00 (asynchronous): bits 6, 5, 4 and 3.
  - 2'b01 (byte-synchronous): bits 5, 3 and 2.
  - 2'b10 (HDLC): bits 7 to 2.
  - 2'b11: no flag bits.
- R6: The queue holds DEPTH (32) entries. A push while full and not popping is dropped. That dropped push sets the overrun flag (status bit 3, `wr_flags[1]`) on the most recently stored entry.
- R7: A push and a pop in the same cycle on a non-empty queue keep the occupancy unchanged and keep the entry order.
- R8: Each of `rx_reset`, `chan_reset` and `sys_stop`, when high at a clock edge, empties the queue. `cur_status` is then 8'h00 in the next cycle.
- R9: A `rd_pop` on an empty queue has no effect: `cur_status` stays 8'h00 and a later push lands at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_reset | input | 1 | Receive-reset command, empties the queue |
| chan_reset | input | 1 | Channel-reset command, empties the queue |
| sys_stop | input | 1 | System stop, empties the queue |
| mode | input | 2 | Line mode selecting the flag mask |
| wr_en | input | 1 | Push strobe from the receiver |
| wr_data | input | 8 | Received character |
| wr_flags | input | 6 | Flags for status bits 7..2 |
| rd_pop | input | 1 | CPU read of the data register, advances the head |
| rd_data | output | 8 | Head character, 0 when empty |
| cur_status | output | 8 | Current status of the head entry |

## Verification
The bench uses several input patterns, and each one separates a different class of error:
- **Single pushes with distinct flag patterns.** These catch a status byte that lags its data, or flags that are wired to the wrong bits.
- **One flag word with all bits set, read under every mode.** This catches a wrong mask in any one mode.
- **A full fill followed by one more push.** This separates a dropped push from an accepted one, and catches an overrun stamped on the wrong entry.
- **Mixed simultaneous push-and-pop, pops on an empty queue, and each clear source on its own.** These expose order, count and clear-path faults that plain streaming would hide.

// File: rtl/rxq_pkg.sv
// Package: shared types and the mode-to-flag mask for the receive status FIFO.
// Assumes flags are indexed so that flag i lands in status bit i+2.
package rxq_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'b00,
        MODE_BYTE  = 2'b01,
        MODE_HDLC  = 2'b10,
        MODE_NONE  = 2'b11
    } rxq_mode_e;

    localparam int FLAG_W  = 6;
    localparam int OVR_IDX = 1;   // flag index of the overrun bit (status bit 3)

    // Flags each mode is allowed to show
    function automatic logic [FLAG_W-1:0] mode_mask(input logic [1:0] m);
        logic [FLAG_W-1:0] r;
        case (m)
            MODE_ASYNC: r = 6'b011110;
            MODE_BYTE:  r = 6'b001011;
            MODE_HDLC:  r = 6'b111111;
            default:    r = 6'b000000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rxq_ptr_ctrl.sv
// Pointer and occupancy control for the receive queue.
// Decides which pushes and pops take effect and when an overrun stamp is due.
// Assumes pop is evaluated before push, so a full queue accepts a push in a popping cycle.
module rxq_ptr_ctrl #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push_req,
    input  logic          pop_req,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] last_ptr,
    output logic [CW-1:0] occ,
    output logic          push_ok,
    output logic          stamp_ovr,
    output logic          nonempty
);

    logic pop_ok;
    logic full;

    // Accept or reject this cycle's requests
    always_comb begin
        nonempty  = (occ != '0);
        full      = (occ == CW'(DEPTH));
        pop_ok    = pop_req && nonempty;
        push_ok   = push_req && (!full || pop_ok);
        stamp_ovr = push_req && !push_ok;
        last_ptr  = (wr_ptr == '0) ? AW'(DEPTH - 1) : wr_ptr - 1'b1;
    end

    // Advance the write pointer on each accepted push
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            wr_ptr <= '0;
        else if (push_ok)
            wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    end

    // Advance the read pointer on each accepted pop
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            rd_ptr <= '0;
        else if (pop_ok)
            rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end

    // Track how many entries are held
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            occ <= '0;
        else begin
            case ({push_ok, pop_ok})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

endmodule

// File: rtl/rxq_store.sv
// Storage for characters and their flag words, with the overrun stamp on the newest entry.
// Assumes the controller never asserts push_ok and stamp_ovr together.
module rxq_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    parameter int FLAG_W = 6,
    parameter int OVR_IDX = 1,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              push_ok,
    input  logic              stamp_ovr,
    input  logic [AW-1:0]     wr_ptr,
    input  logic [AW-1:0]     rd_ptr,
    input  logic [AW-1:0]     last_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FLAG_W-1:0] wr_flags,
    output logic [DATA_W-1:0] head_data,
    output logic [FLAG_W-1:0] head_flags
);

    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [FLAG_W-1:0] flag_mem [DEPTH];

    // Write the character slot on an accepted push
    always_ff @(posedge clk) begin
        if (push_ok)
            data_mem[wr_ptr] <= wr_data;
    end

    // Write flags on a push, or set overrun on the newest entry on a dropped push
    always_ff @(posedge clk) begin
        if (push_ok)
            flag_mem[wr_ptr] <= wr_flags;
        else if (stamp_ovr)
            flag_mem[last_ptr][OVR_IDX] <= 1'b1;
    end

    // Present the head entry without a register stage
    always_comb begin
        head_data  = data_mem[rd_ptr];
        head_flags = flag_mem[rd_ptr];
    end

endmodule

// File: rtl/rxq_status_view.sv
// Builds the current-status byte and the visible data from the head entry.
// Assumes head contents are only meaningful while nonempty is high.
module rxq_status_view #(
    parameter int DATA_W = 8,
    parameter int FLAG_W = 6
) (
    input  logic              nonempty,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] head_data,
    input  logic [FLAG_W-1:0] head_flags,
    output logic [DATA_W-1:0] rd_data,
    output logic [FLAG_W+1:0] cur_status
);
    import rxq_pkg::*;

    // Mask flags by mode and force empty-queue outputs to zero
    always_comb begin
        if (nonempty) begin
            rd_data    = head_data;
            cur_status = {head_flags & mode_mask(mode), 1'b0, 1'b1};
        end else begin
            rd_data    = '0;
            cur_status = '0;
        end
    end

endmodule

// File: rtl/rxq_status_fifo.sv
// Top: receive character queue with a head-of-queue status byte.
// Assumes all clear sources are synchronous to clk; no output drives an interrupt.
module rxq_status_fifo #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    localparam int FLAG_W = rxq_pkg::FLAG_W,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_reset,
    input  logic              chan_reset,
    input  logic              sys_stop,
    input  logic [1:0]        mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FLAG_W-1:0] wr_flags,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [FLAG_W+1:0] cur_status
);

    logic          clear;
    logic [AW-1:0] wr_ptr, rd_ptr, last_ptr;
    logic [CW-1:0] occ;
    logic          push_ok, stamp_ovr, nonempty;
    logic [DATA_W-1:0] head_data;
    logic [FLAG_W-1:0] head_flags;

    // Merge the three clear sources
    always_comb clear = rx_reset || chan_reset || sys_stop;

    rxq_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .push_req(wr_en), .pop_req(rd_pop),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .last_ptr(last_ptr), .occ(occ),
        .push_ok(push_ok), .stamp_ovr(stamp_ovr), .nonempty(nonempty)
    );

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .FLAG_W(FLAG_W),
                .OVR_IDX(rxq_pkg::OVR_IDX)) u_store (
        .clk(clk), .push_ok(push_ok), .stamp_ovr(stamp_ovr),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .last_ptr(last_ptr),
        .wr_data(wr_data), .wr_flags(wr_flags),
        .head_data(head_data), .head_flags(head_flags)
    );

    rxq_status_view #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_view (
        .nonempty(nonempty), .mode(mode),
        .head_data(head_data), .head_flags(head_flags),
        .rd_data(rd_data), .cur_status(cur_status)
    );

endmodule

// File: rtl/rxq_status_fifo_chk.sv
// Checker for rxq_status_fifo, attached by bind; observes ports and occupancy.
// Assumes it is bound with the top's DEPTH.
module rxq_status_fifo_chk #(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_reset,
    input logic          chan_reset,
    input logic          sys_stop,
    input logic [1:0]    mode,
    input logic          wr_en,
    input logic          rd_pop,
    input logic [7:0]    cur_status,
    input logic [CW-1:0] occ
);
    logic clr;
    always_comb clr = rx_reset || chan_reset || sys_stop;

    a_r5_bit1_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cur_status[1] == 1'b0);

    a_r5_none_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> (cur_status[7:2] == 6'b0));

    a_r5_async_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> (cur_status[7] == 1'b0 && cur_status[2] == 1'b0));

    a_r2_push_shows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> cur_status[0]);

    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cur_status == 8'h00));

    a_r9_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_status[0] && rd_pop && !wr_en && !clr) |=> (cur_status == 8'h00));

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    a_r7_swap_keeps_occ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_pop && occ != '0 && !clr) |=> $stable(occ));

endmodule

bind rxq_status_fifo rxq_status_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset), .chan_reset(chan_reset),
    .sys_stop(sys_stop), .mode(mode), .wr_en(wr_en), .rd_pop(rd_pop),
    .cur_status(cur_status), .occ(occ)
);

// File: tb/tb_rxq_status_fifo.sv
// Scoreboard bench: the driver queues expected entries, the monitor compares the head.
module tb_rxq_status_fifo;

    typedef struct packed { logic [7:0] d; logic [5:0] f; } item_t;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       rx_reset = 0, chan_reset = 0, sys_stop = 0;
    logic [1:0] mode = 2'b10;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic [5:0] wr_flags = 0;
    logic       rd_pop = 0;
    logic [7:0] rd_data;
    logic [7:0] cur_status;

    item_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rxq_status_fifo dut (
        .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset), .chan_reset(chan_reset),
        .sys_stop(sys_stop), .mode(mode), .wr_en(wr_en), .wr_data(wr_data),
        .wr_flags(wr_flags), .rd_pop(rd_pop), .rd_data(rd_data), .cur_status(cur_status)
    );

    function automatic logic [5:0] exp_mask(input logic [1:0] m);
        case (m)
            2'b00:   return 6'b011110;
            2'b01:   return 6'b001011;
            2'b10:   return 6'b111111;
            default: return 6'b000000;
        endcase
    endfunction

    // Monitor: compare head outputs against the scoreboard front
    task automatic compare(input string tag);
        logic [7:0] es, ed;
        if (sb.size() == 0) begin es = 8'h00; ed = 8'h00; end
        else begin
            es = {sb[0].f & exp_mask(mode), 2'b01};
            ed = sb[0].d;
        end
        checks++;
        if (cur_status !== es || rd_data !== ed) begin
            errors++;
            $display("FAIL %s: status=%h data=%h expected status=%h data=%h",
                     tag, cur_status, rd_data, es, ed);
        end
    endtask

    // Driver: one clock of stimulus, scoreboard update, then compare
    task automatic step(input logic we, input logic [7:0] d, input logic [5:0] f,
                        input logic pop, input logic [2:0] clr, input string tag);
        bit pop_ok;
        wr_en = we; wr_data = d; wr_flags = f; rd_pop = pop;
        rx_reset = clr[0]; chan_reset = clr[1]; sys_stop = clr[2];
        @(posedge clk);
        if (clr != 0) sb.delete();
        else begin
            pop_ok = pop && sb.size() > 0;
            if (pop_ok) void'(sb.pop_front());
            if (we) begin
                if (sb.size() < 32) sb.push_back('{d: d, f: f});
                else sb[sb.size()-1].f[1] = 1'b1;
            end
        end
        @(negedge clk);
        wr_en = 0; rd_pop = 0; rx_reset = 0; chan_reset = 0; sys_stop = 0;
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare("R1 reset empty");

        // R2/R3/R4: distinct flag patterns in HDLC mode
        step(1, 8'hA1, 6'b100001, 0, 0, "R2 first push visible");
        step(1, 8'hB2, 6'b010100, 0, 0, "R3 second push keeps head");
        step(1, 8'hC3, 6'b001010, 0, 0, "R3 third push keeps head");
        step(0, 0, 0, 1, 0, "R3 pop advances to second");
        step(0, 0, 0, 1, 0, "R3 pop advances to third");
        step(0, 0, 0, 1, 0, "R4 last pop clears status");

        // R5: one all-ones flag word under each mode
        step(1, 8'h5A, 6'b111111, 0, 0, "R5 push all flags");
        for (int m = 0; m < 4; m++) begin
            mode = m[1:0];
            #1 compare($sformatf("R5 mask mode %0d", m));
        end
        mode = 2'b10;
        step(0, 0, 0, 1, 0, "R5 drain");

        // R9: pop on empty, then push lands at head
        step(0, 0, 0, 1, 0, "R9 pop on empty ignored");
        step(1, 8'h77, 6'b000100, 0, 0, "R9 push after empty pop");
        step(0, 0, 0, 1, 0, "R9 drain");

        // R6: fill to 32 then overflow; drain and confirm stamp on newest entry
        for (int i = 0; i < 32; i++)
            step(1, 8'(i + 16), 6'(i) & 6'b111101, 0, 0, "R6 fill");
        step(1, 8'hEE, 6'b000000, 0, 0, "R6 overflow push dropped");
        for (int i = 0; i < 32; i++)
            step(0, 0, 0, 1, 0, "R6 drain order and overrun stamp");

        // R7: simultaneous push and pop keeps order
        step(1, 8'h11, 6'b000001, 0, 0, "R7 seed one");
        step(1, 8'h22, 6'b000010, 0, 0, "R7 seed two");
        step(1, 8'h33, 6'b000100, 1, 0, "R7 swap one");
        step(1, 8'h44, 6'b001000, 1, 0, "R7 swap two");
        step(0, 0, 0, 1, 0, "R7 pop after swaps");
        step(0, 0, 0, 1, 0, "R7 pop after swaps");
        step(0, 0, 0, 1, 0, "R7 empty after swaps");

        // R8: each clear source on its own
        for (int c = 0; c < 3; c++) begin
            step(1, 8'h60 + 8'(c), 6'b110000, 0, 0, "R8 load before clear");
            step(1, 8'h70 + 8'(c), 6'b000011, 0, 0, "R8 load before clear");
            step(0, 0, 0, 0, 3'(1 << c), $sformatf("R8 clear source %0d", c));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule